// File: doc/BRIEF.md
# Interleaved Sum and Sum-of-Squares Accumulator

This block takes one signed fixed-point sample per clock and folds every accepted sample into a running sum, a running sum of squares and a shared sample count. The adders in the feedback loop are split across three register stages. Three independent partial states therefore circulate around the loop, one per stage. Each incoming sample joins whichever state is leaving the adder in that cycle, so the input never stalls.

A host collects results by holding the read request for three cycles. The three partial states then come out one per cycle and are cleared as they leave. The host adds the emitted sums together, and the emitted sums of squares together, to get the totals it needs for a mean and a variance. The count is kept once for all states. Each accepted sample is reported in exactly one emitted count value, so adding every emitted count gives the number of accepted samples.

Top module: `cslow_stat_acc`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and count_o, sum_o and sumsq_o are all 0.
- R2: A read request sampled on a rising edge asserts valid_o after the third rising edge, counting that one. Each requested cycle gives exactly one valid_o cycle.
- R3: A cycle with valid_i low adds zero to the sum, the sum of squares and the count, whatever x_i holds.
- R4: Adding up count_o over all valid_o cycles gives the number of samples accepted with valid_i high. Two back-to-back valid_o cycles never show a count above 1 on the second one.
- R5: A read held for three consecutive cycles emits all three partial states. After all accepted samples have drained, the emitted sums and sums of squares add up to the full totals.
- R6: Each emitted state is cleared, so an immediate second three-cycle read with no new samples emits only zeros.
- R7: A valid sample that meets a state in the cycle that state is cleared is added to the zeroed state. It is not lost and shows up in the next readout.
- R8: Sums are exact two's-complement totals of the 16-bit samples, including -32768. Squares are exact (x*x as an unsigned value). The widths hold 2^30 samples without overflow.
- R9: A single-cycle read emits one partial state only. The other two states keep their contents for later reads.
- R10: When valid_o is low, count_o, sum_o and sumsq_o hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_i | input | DATA_W | Signed sample |
| valid_i | input | 1 | Sample qualifier |
| rd_i | input | 1 | Read-and-clear request, one state per cycle |
| count_o | output | LOG_N+1 | Shared counter value, cleared on each read cycle |
| sum_o | output | DATA_W+LOG_N | Emitted partial sum (signed) |
| sumsq_o | output | 2*DATA_W+LOG_N | Emitted partial sum of squares |
| valid_o | output | 1 | Emitted state is valid |

## Verification
A read request reaches the outputs after three rising edges. A sample needs two edges to get squared and aligned, then three more to pass around the adder loop before any read can see it. The bench drives inputs just after each falling edge and samples just after the next falling edge. It checks the read latency edge by edge. It waits at least eight idle cycles after the last sample before it starts any drain read. Totals are compared against arithmetic sums built from the driven stimulus, including a sweep over every 16-bit value with a pseudo-random valid pattern and reads interleaved with samples.

// File: rtl/cslow_acc_pkg.sv
package cslow_acc_pkg;
  // registers from the pins to the adder loop entry
  localparam int unsigned ALIGN_STAGES = 2;
  // stages in the adder loop = number of interleaved partial states
  localparam int unsigned ADD_STAGES   = 3;
  // rd_i edge to valid_o, in rising edges
  localparam int unsigned READ_LAT     = ALIGN_STAGES + 1;

  typedef struct packed {
    logic vld;
    logic rd;
  } ctl_t;
endpackage

// File: rtl/cslow_acc_align.sv
module cslow_acc_align
  import cslow_acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SQ_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] x_i,
  input  logic              valid_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] x_o,
  output logic [SQ_W-1:0]   sq_o,
  output logic              valid_o,
  output logic              rd_o
);
  logic signed [DATA_W-1:0] x1_q;
  ctl_t                     c1_q, c2_q;
  logic [DATA_W-1:0]        x2_q;
  logic [SQ_W-1:0]          sq2_q;
  logic signed [SQ_W-1:0]   x1_ext;
  logic signed [SQ_W-1:0]   prod;

  assign x1_ext = SQ_W'(x1_q);
  assign prod   = x1_ext * x1_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q  <= '0;
      c1_q  <= '0;
      x2_q  <= '0;
      sq2_q <= '0;
      c2_q  <= '0;
    end else begin
      x1_q  <= x_i;
      c1_q  <= '{vld: valid_i, rd: rd_i};
      // invalid slots become zero addends; the loop never stalls
      x2_q  <= c1_q.vld ? x1_q : '0;
      sq2_q <= c1_q.vld ? prod : '0;
      c2_q  <= c1_q;
    end
  end

  assign x_o     = x2_q;
  assign sq_o    = sq2_q;
  assign valid_o = c2_q.vld;
  assign rd_o    = c2_q.rd;
endmodule

// File: rtl/cslow_acc_pipe_add.sv
module cslow_acc_pipe_add #(
  parameter int unsigned W = 46
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned LO_W = W / 2;
  localparam int unsigned HI_W = W - LO_W;

  logic [W-1:0]    a1_q, b1_q;
  logic [LO_W-1:0] lo2_q;
  logic            c2_q;
  logic [HI_W-1:0] ahi2_q, bhi2_q;
  logic [W-1:0]    s3_q;
  logic [LO_W:0]   lo_sum;

  assign lo_sum = {1'b0, a1_q[LO_W-1:0]} + {1'b0, b1_q[LO_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a1_q   <= '0;
      b1_q   <= '0;
      lo2_q  <= '0;
      c2_q   <= 1'b0;
      ahi2_q <= '0;
      bhi2_q <= '0;
      s3_q   <= '0;
    end else begin
      a1_q   <= a_i;
      b1_q   <= b_i;
      lo2_q  <= lo_sum[LO_W-1:0];
      c2_q   <= lo_sum[LO_W];
      ahi2_q <= a1_q[W-1:LO_W];
      bhi2_q <= b1_q[W-1:LO_W];
      s3_q   <= {ahi2_q + bhi2_q + HI_W'(c2_q), lo2_q};
    end
  end

  assign sum_o = s3_q;
endmodule

// File: rtl/cslow_acc_counter.sv
module cslow_acc_counter #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= (clr_i ? '0 : cnt_q) + CNT_W'(inc_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cslow_stat_acc.sv
module cslow_stat_acc
  import cslow_acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LOG_N  = 30
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DATA_W-1:0]            x_i,
  input  logic                         valid_i,
  input  logic                         rd_i,
  output logic [LOG_N:0]               count_o,
  output logic [DATA_W+LOG_N-1:0]      sum_o,
  output logic [2*DATA_W+LOG_N-1:0]    sumsq_o,
  output logic                         valid_o
);
  localparam int unsigned SQ_W  = 2 * DATA_W;
  localparam int unsigned SUM_W = DATA_W + LOG_N;
  localparam int unsigned SSQ_W = SQ_W + LOG_N;
  localparam int unsigned CNT_W = LOG_N + 1;

  logic [DATA_W-1:0] al_x;
  logic [SQ_W-1:0]   al_sq;
  logic              al_vld, al_rd;
  logic [SUM_W-1:0]  ring_sum, loop_sum_a, loop_sum_b;
  logic [SSQ_W-1:0]  ring_sq, loop_sq_a, loop_sq_b;
  logic [CNT_W-1:0]  cnt;

  cslow_acc_align #(.DATA_W(DATA_W), .SQ_W(SQ_W)) u_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_i),
    .valid_i (valid_i),
    .rd_i    (rd_i),
    .x_o     (al_x),
    .sq_o    (al_sq),
    .valid_o (al_vld),
    .rd_o    (al_rd)
  );

  // leaving state is zeroed when read; the aligned sample still joins it
  assign loop_sum_a = al_rd ? '0 : ring_sum;
  assign loop_sq_a  = al_rd ? '0 : ring_sq;
  assign loop_sum_b = {{(SUM_W-DATA_W){al_x[DATA_W-1]}}, al_x};
  assign loop_sq_b  = {{(SSQ_W-SQ_W){1'b0}}, al_sq};

  cslow_acc_pipe_add #(.W(SUM_W)) u_add_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (loop_sum_a),
    .b_i    (loop_sum_b),
    .sum_o  (ring_sum)
  );

  cslow_acc_pipe_add #(.W(SSQ_W)) u_add_sq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (loop_sq_a),
    .b_i    (loop_sq_b),
    .sum_o  (ring_sq)
  );

  cslow_acc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (al_vld),
    .clr_i  (al_rd),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      sum_o   <= '0;
      sumsq_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= al_rd;
      if (al_rd) begin
        count_o <= cnt;
        sum_o   <= ring_sum;
        sumsq_o <= ring_sq;
      end
    end
  end
endmodule

// File: rtl/cslow_stat_acc_chk.sv
module cslow_stat_acc_chk
  import cslow_acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LOG_N  = 30
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      rd_i,
  input logic                      valid_o,
  input logic [LOG_N:0]            count_o,
  input logic [DATA_W+LOG_N-1:0]   sum_o,
  input logic [2*DATA_W+LOG_N-1:0] sumsq_o
);
  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!valid_o && count_o == '0 && sum_o == '0 && sumsq_o == '0);
    end
  end

  // R2
  read_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (valid_o == $past(rd_i, READ_LAT)));

  // R10
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sum_o) && $stable(sumsq_o) && $stable(count_o)));

  // R4
  b2b_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (count_o <= 1));
endmodule

bind cslow_stat_acc cslow_stat_acc_chk #(.DATA_W(DATA_W), .LOG_N(LOG_N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .valid_o (valid_o),
  .count_o (count_o),
  .sum_o   (sum_o),
  .sumsq_o (sumsq_o)
);

// File: tb/cslow_stat_acc_bench.sv
module cslow_stat_acc_bench;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LOG_N  = 30;

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic [DATA_W-1:0]         x_i = '0;
  logic                      valid_i = 1'b0;
  logic                      rd_i = 1'b0;
  logic [LOG_N:0]            count_o;
  logic [DATA_W+LOG_N-1:0]   sum_o;
  logic [2*DATA_W+LOG_N-1:0] sumsq_o;
  logic                      valid_o;

  int total = 0;
  int bad   = 0;

  longint m_sum = 0, m_sq = 0, m_cnt = 0, m_n = 0;
  longint s_sum, s_sq, s_cnt, s_n;

  always #5 clk_i = ~clk_i;

  cslow_stat_acc #(.DATA_W(DATA_W), .LOG_N(LOG_N)) u_cslow_stat_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_i),
    .valid_i (valid_i),
    .rd_i    (rd_i),
    .count_o (count_o),
    .sum_o   (sum_o),
    .sumsq_o (sumsq_o),
    .valid_o (valid_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      m_sum += longint'($signed(sum_o));
      m_sq  += longint'(sumsq_o);
      m_cnt += longint'(count_o);
      m_n   += 1;
    end
  end

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic step(input logic v, input logic [DATA_W-1:0] x, input logic r);
    valid_i = v;
    x_i     = x;
    rd_i    = r;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
  endtask

  task automatic snap();
    s_sum = m_sum; s_sq = m_sq; s_cnt = m_cnt; s_n = m_n;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drain_read();
    idle(8);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
    idle(4);
  endtask

  initial begin
    longint e_sum, e_sq, e_cnt, first;
    logic [15:0] lfsr;
    logic v;
    logic signed [DATA_W-1:0] xs;

    repeat (3) tick();
    // R1 reset state
    chk("R1 valid", longint'(valid_o), 0);
    chk("R1 sum", longint'(sum_o), 0);
    chk("R1 sumsq", longint'(sumsq_o), 0);
    chk("R1 count", longint'(count_o), 0);
    rst_ni = 1'b1;
    tick();

    // R2 latency of a single read cycle
    step(1'b0, '0, 1'b1);
    rd_i = 1'b0;
    chk("R2 edge1", longint'(valid_o), 0);
    tick();
    chk("R2 edge2", longint'(valid_o), 0);
    tick();
    chk("R2 edge3", longint'(valid_o), 1);
    tick();
    chk("R2 after", longint'(valid_o), 0);
    idle(4);

    // R3 invalid cycles with nonzero data contribute nothing
    for (int i = 0; i < 20; i++) step(1'b0, 16'h3039, 1'b0);
    snap();
    drain_read();
    chk("R3 sum", m_sum - s_sum, 0);
    chk("R3 sumsq", m_sq - s_sq, 0);
    chk("R3 count", m_cnt - s_cnt, 0);

    // R9 single read emits one state, others keep contents
    step(1'b1, 16'd100, 1'b0);
    step(1'b1, 16'd2000, 1'b0);
    step(1'b1, 16'hFFFB, 1'b0); // -5
    idle(8);
    snap();
    step(1'b0, '0, 1'b1);
    idle(4);
    first = m_sum - s_sum;
    chk("R9 one state", m_n - s_n, 1);
    chk("R9 count", m_cnt - s_cnt, 3);
    chk("R9 sum is one sample", longint'(first == 100 || first == 2000 || first == -5), 1);
    snap();
    drain_read();
    chk("R9 rest sum", m_sum - s_sum, 2095 - first);
    chk("R9 rest count", m_cnt - s_cnt, 0);

    // R7 samples arriving in the clearing cycles
    snap();
    step(1'b1, 16'd5, 1'b1);
    step(1'b1, 16'd6, 1'b1);
    step(1'b1, 16'd7, 1'b1);
    idle(4);
    chk("R7 burst sum", m_sum - s_sum, 0);
    chk("R7 burst count", m_cnt - s_cnt, 2);
    snap();
    drain_read();
    chk("R7 flush sum", m_sum - s_sum, 18);
    chk("R7 flush sumsq", m_sq - s_sq, 110);
    chk("R7 flush count", m_cnt - s_cnt, 1);

    // R6 second read right after clearing
    snap();
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1);
    idle(4);
    chk("R6 sum", m_sum - s_sum, 0);
    chk("R6 sumsq", m_sq - s_sq, 0);
    chk("R6 count", m_cnt - s_cnt, 0);
    chk("R10 valid cycles", m_n - s_n, 3);

    // R8/R4/R5 sweep over every sample value with interleaved reads
    snap();
    e_sum = 0; e_sq = 0; e_cnt = 0;
    lfsr = 16'hACE1;
    for (int i = 0; i < 65536; i++) begin
      xs = DATA_W'(i - 32768);
      v  = lfsr[0] | (i == 0) | (i == 65535);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(v, xs, (i % 4096) >= 4093);
      if (v) begin
        e_sum += longint'(xs);
        e_sq  += longint'(xs) * longint'(xs);
        e_cnt += 1;
      end
    end
    drain_read();
    chk("R8 sweep sum", m_sum - s_sum, e_sum);
    chk("R8 sweep sumsq", m_sq - s_sq, e_sq);
    chk("R4 sweep count", m_cnt - s_cnt, e_cnt);
    chk("R5 sweep read cycles", m_n - s_n, 16 * 3 + 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule